// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the three status flags of a double-buffered synchronous serial port. The flags are transmit done, transmit buffer free and receive buffer holding data. It also holds the transmit and receive data buffers. It copies the transmit buffer into the shifter's word when the shift engine asks for it, and it captures each correctly received word from the shift engine.

The CPU side sees four strobes: status read, status write, transmit-data write and receive-data read. Each flag has its own interrupt request line, and that line mirrors the flag. Software may clear a flag only by writing 0 to it after a status read has shown that flag as 1. A mode input chooses whether transmit done rises on the last-bit strobe or one clock later.

Top module: `sspf_top`

## Requirements
- R1: After a synchronous active-low reset, `status` is 3'b110. Bit 2 is transmit done (1), bit 1 is transmit buffer free (1) and bit 0 is receive buffer full (0). This bit layout applies to `status`, `cpu_wdata` and the interrupt lines throughout.
- R2: While `tx_en` is 0, bit 1 of `status` reads 1 from the next clock on, even after a transmit-data write.
- R3: `eng_tx_load` sets bit 1 of `status` and copies the transmit buffer to `tx_shift_word`, both at the next clock.
- R4: A `cpu_txd_wr` with `tx_en` at 1 clears bit 1 of `status` at the next clock, unless a set event lands in the same cycle.
- R5: A `cpu_txd_wr` clears bit 2 of `status` at the next clock, whatever the value of `tx_en`.
- R6: With `tend_late` at 0, an `eng_last_bit` strobe sampled while bit 1 of `status` is 1 sets bit 2 at the next clock. If bit 1 is 0, the strobe sets nothing.
- R7: With `tend_late` at 1, bit 2 of `status` is set one clock later than in R6. The condition is that bit 1 is 1 in the cycle after the strobe.
- R8: `eng_rx_done` sets bit 0 of `status` and loads `eng_rx_word` into `rxd_out`, both at the next clock.
- R9: A `cpu_rxd_rd` clears bit 0 of `status` at the next clock.
- R10: A status write with a 0 in a flag's bit clears that flag only if the previous status read returned 1 for it. Each status write consumes the read. Writing 1 leaves a flag unchanged.
- R11: When a hardware set event and any clear land in the same cycle, the flag ends up 1.
- R12: `irq_tend`, `irq_tdre` and `irq_rdrf` equal bits 2, 1 and 0 of `status` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_stat_rd | input | 1 | Status read strobe (arms clears) |
| cpu_stat_wr | input | 1 | Status write strobe |
| cpu_wdata | input | 3 | Status write data |
| cpu_txd_wr | input | 1 | Transmit buffer write strobe |
| cpu_txd | input | DATA_W | Transmit buffer write data |
| cpu_rxd_rd | input | 1 | Receive buffer read strobe |
| tx_en | input | 1 | Transmit enable |
| tend_late | input | 1 | Transmit-done timing select |
| eng_tx_load | input | 1 | Shifter takes the transmit buffer |
| eng_last_bit | input | 1 | Last transmit bit strobe |
| eng_rx_done | input | 1 | Received word valid |
| eng_rx_word | input | DATA_W | Received word |
| tx_shift_word | output | DATA_W | Word handed to the shifter |
| rxd_out | output | DATA_W | Receive buffer contents |
| status | output | 3 | Flags {done, free, full} |
| irq_tend | output | 1 | Transmit done request |
| irq_tdre | output | 1 | Transmit buffer free request |
| irq_rdrf | output | 1 | Receive full request |

## Verification
Every flag and buffer is a register, so each strobe or set event shows its result one clock later. The one exception is the late transmit-done mode, which needs two clocks from the strobe. The bench drives inputs at the falling edge and samples at the next falling edge, which puts exactly one rising edge between stimulus and check. For the late mode it checks once after the first edge, expecting no change, and again after the second edge. The clear-arming rule is checked as an ordered sequence: a write with no read, then a read followed by a write, then a repeated write.

// File: rtl/sspf_pkg.sv
// Package: flag bit positions shared by the block, its checker and its bench.
package sspf_pkg;
    localparam int NFLAG = 3;
    localparam int F_RDRF = 0;
    localparam int F_TDRE = 1;
    localparam int F_TEND = 2;
endpackage

// File: rtl/sspf_arm.sv
// Module: per-flag clear arming.
// A status read that shows a flag as 1 arms that flag. The next status write
// consumes every arm bit, and a 0 written to an armed flag asks for its clear.
// Assumes flags are registered and stable across the read cycle.
module sspf_arm #(
    parameter int NF = sspf_pkg::NFLAG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stat_rd,
    input  logic          stat_wr,
    input  logic [NF-1:0] wdata,
    input  logic [NF-1:0] flags,
    output logic [NF-1:0] clr_req
);
    logic [NF-1:0] arm_q;

    for (genvar i = 0; i < NF; i++) begin : g_arm
        // Track "read as 1": set on a read, consumed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                arm_q[i] <= 1'b0;
            else if (stat_rd && flags[i])
                arm_q[i] <= 1'b1;
            else if (stat_wr)
                arm_q[i] <= 1'b0;
        end
        // Clear request only for an armed flag written with 0.
        assign clr_req[i] = stat_wr && !wdata[i] && arm_q[i];
    end
endmodule

// File: rtl/sspf_tx.sv
// Module: transmit buffer, shifter handoff, free flag and done flag.
// Assumes the engine strobes eng_tx_load only when it takes a new word,
// and pulses eng_last_bit for one cycle per word.
module sspf_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              tend_late,
    input  logic              txd_wr,
    input  logic [DATA_W-1:0] txd,
    input  logic              tx_load,
    input  logic              last_bit,
    input  logic              clr_tdre,
    input  logic              clr_tend,
    output logic [DATA_W-1:0] shift_word,
    output logic              tdre,
    output logic              tend
);
    logic [DATA_W-1:0] buf_q;
    logic              last_d;
    logic              tend_set;

    // Hold the CPU's transmit word.
    always_ff @(posedge clk) begin
        if (!rst_n)         buf_q <= '0;
        else if (txd_wr)    buf_q <= txd;
    end

    // Hand the buffer to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n)         shift_word <= '0;
        else if (tx_load)   shift_word <= buf_q;
    end

    // Buffer-free flag: forced while disabled, set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tdre <= 1'b1;
        else if (!tx_en || tx_load)     tdre <= 1'b1;
        else if (txd_wr || clr_tdre)    tdre <= 1'b0;
    end

    // Delay the last-bit strobe for the late timing mode.
    always_ff @(posedge clk) begin
        if (!rst_n) last_d <= 1'b0;
        else        last_d <= last_bit;
    end

    assign tend_set = tdre && (tend_late ? last_d : last_bit);

    // Done flag: set beats both clear sources.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tend <= 1'b1;
        else if (tend_set)              tend <= 1'b1;
        else if (txd_wr || clr_tend)    tend <= 1'b0;
    end
endmodule

// File: rtl/sspf_rx.sv
// Module: receive buffer and its full flag.
// Assumes eng_rx_done is raised only for a correctly received word.
module sspf_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rxd_rd,
    input  logic              clr_rdrf,
    output logic [DATA_W-1:0] rxd,
    output logic              rdrf
);
    // Capture the received word.
    always_ff @(posedge clk) begin
        if (!rst_n)         rxd <= '0;
        else if (rx_done)   rxd <= rx_word;
    end

    // Full flag: set beats a read or a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rdrf <= 1'b0;
        else if (rx_done)               rdrf <= 1'b1;
        else if (rxd_rd || clr_rdrf)    rdrf <= 1'b0;
    end
endmodule

// File: rtl/sspf_top.sv
// Module: status flag controller top.
// Joins the arming logic with the transmit and receive paths.
// Interrupt requests mirror the flags.
module sspf_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_stat_rd,
    input  logic              cpu_stat_wr,
    input  logic [2:0]        cpu_wdata,
    input  logic              cpu_txd_wr,
    input  logic [DATA_W-1:0] cpu_txd,
    input  logic              cpu_rxd_rd,
    input  logic              tx_en,
    input  logic              tend_late,
    input  logic              eng_tx_load,
    input  logic              eng_last_bit,
    input  logic              eng_rx_done,
    input  logic [DATA_W-1:0] eng_rx_word,
    output logic [DATA_W-1:0] tx_shift_word,
    output logic [DATA_W-1:0] rxd_out,
    output logic [2:0]        status,
    output logic              irq_tend,
    output logic              irq_tdre,
    output logic              irq_rdrf
);
    import sspf_pkg::*;

    logic [NFLAG-1:0] clr;
    logic             tdre, tend, rdrf;

    assign status = {tend, tdre, rdrf};

    sspf_arm #(.NF(NFLAG)) arm_i (
        .clk(clk), .rst_n(rst_n), .stat_rd(cpu_stat_rd), .stat_wr(cpu_stat_wr),
        .wdata(cpu_wdata), .flags(status), .clr_req(clr)
    );

    sspf_tx #(.DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tend_late(tend_late),
        .txd_wr(cpu_txd_wr), .txd(cpu_txd), .tx_load(eng_tx_load),
        .last_bit(eng_last_bit), .clr_tdre(clr[F_TDRE]), .clr_tend(clr[F_TEND]),
        .shift_word(tx_shift_word), .tdre(tdre), .tend(tend)
    );

    sspf_rx #(.DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .rx_done(eng_rx_done), .rx_word(eng_rx_word),
        .rxd_rd(cpu_rxd_rd), .clr_rdrf(clr[F_RDRF]), .rxd(rxd_out), .rdrf(rdrf)
    );

    assign irq_tend = tend;
    assign irq_tdre = tdre;
    assign irq_rdrf = rdrf;
endmodule

// File: rtl/sspf_chk.sv
// Checker: port-level properties of sspf_top, attached by bind.
// Keeps its own record of reads that showed receive-full as 1.
module sspf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_stat_rd,
    input logic       cpu_stat_wr,
    input logic [2:0] cpu_wdata,
    input logic       cpu_txd_wr,
    input logic       cpu_rxd_rd,
    input logic       tx_en,
    input logic       tend_late,
    input logic       eng_tx_load,
    input logic       eng_last_bit,
    input logic       eng_rx_done,
    input logic [2:0] status,
    input logic       irq_tend,
    input logic       irq_tdre,
    input logic       irq_rdrf
);
    logic seen_full;

    // Mirror of the arm state for the receive-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                           seen_full <= 1'b0;
        else if (cpu_stat_rd && status[0])    seen_full <= 1'b1;
        else if (cpu_stat_wr)                 seen_full <= 1'b0;
    end

    AST_FREE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> status[1]); // R2
    AST_LOAD_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        eng_tx_load |=> status[1]); // R3
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en && cpu_txd_wr && !eng_tx_load |=> !status[1]); // R4
    AST_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !tend_late && eng_last_bit && status[1] |=> status[2]); // R6
    AST_LATE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        tend_late && $past(eng_last_bit) && status[1] |=> status[2]); // R7
    AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rx_done |=> status[0]); // R8
    AST_RX_READ: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rxd_rd && !eng_rx_done |=> !status[0]); // R9
    AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stat_wr && !seen_full && !cpu_rxd_rd && status[0] |=> status[0]); // R10
    AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        {irq_tend, irq_tdre, irq_rdrf} == status); // R12
endmodule

bind sspf_top sspf_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_stat_rd(cpu_stat_rd), .cpu_stat_wr(cpu_stat_wr),
    .cpu_wdata(cpu_wdata), .cpu_txd_wr(cpu_txd_wr), .cpu_rxd_rd(cpu_rxd_rd),
    .tx_en(tx_en), .tend_late(tend_late), .eng_tx_load(eng_tx_load),
    .eng_last_bit(eng_last_bit), .eng_rx_done(eng_rx_done), .status(status),
    .irq_tend(irq_tend), .irq_tdre(irq_tdre), .irq_rdrf(irq_rdrf)
);

// File: tb/sspf_top_tb_top.sv
// Directed bench: inputs change at the falling edge, checks follow one falling edge later.
module sspf_top_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_stat_rd = 0, cpu_stat_wr = 0, cpu_txd_wr = 0, cpu_rxd_rd = 0;
    logic [2:0]    cpu_wdata = '0;
    logic [DW-1:0] cpu_txd = '0, eng_rx_word = '0;
    logic          tx_en = 0, tend_late = 0, eng_tx_load = 0, eng_last_bit = 0, eng_rx_done = 0;
    logic [DW-1:0] tx_shift_word, rxd_out;
    logic [2:0]    status;
    logic          irq_tend, irq_tdre, irq_rdrf;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    sspf_top #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_stat_rd(cpu_stat_rd), .cpu_stat_wr(cpu_stat_wr),
        .cpu_wdata(cpu_wdata), .cpu_txd_wr(cpu_txd_wr), .cpu_txd(cpu_txd),
        .cpu_rxd_rd(cpu_rxd_rd), .tx_en(tx_en), .tend_late(tend_late),
        .eng_tx_load(eng_tx_load), .eng_last_bit(eng_last_bit), .eng_rx_done(eng_rx_done),
        .eng_rx_word(eng_rx_word), .tx_shift_word(tx_shift_word), .rxd_out(rxd_out),
        .status(status), .irq_tend(irq_tend), .irq_tdre(irq_tdre), .irq_rdrf(irq_rdrf)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Pulse-style strobes: raise now, drop them all after one edge.
    task automatic idle();
        cpu_stat_rd = 0; cpu_stat_wr = 0; cpu_txd_wr = 0; cpu_rxd_rd = 0;
        eng_tx_load = 0; eng_last_bit = 0; eng_rx_done = 0;
    endtask

    task automatic t_reset();
        chk("R1", status, 3'b110);
        chk("R12", {irq_tend, irq_tdre, irq_rdrf}, 3'b110);
    endtask

    task automatic t_disabled_write();
        tx_en = 0; cpu_txd_wr = 1; cpu_txd = 8'h11; tick(); idle();
        chk("R2", status[1], 1'b1);
        chk("R5", status[2], 1'b0);
    endtask

    task automatic t_tx_flow();
        tx_en = 1; tick();
        cpu_txd_wr = 1; cpu_txd = 8'hA5; tick(); idle();
        chk("R4", status[1], 1'b0);
        eng_tx_load = 1; tick(); idle();
        chk("R3 free", status[1], 1'b1);
        chk("R3 word", tx_shift_word, 8'hA5);
        tend_late = 0; eng_last_bit = 1; tick(); idle();
        chk("R6 set", status[2], 1'b1);
    endtask

    task automatic t_early_blocked();
        cpu_txd_wr = 1; cpu_txd = 8'h5A; tick(); idle();
        eng_last_bit = 1; tick(); idle();
        chk("R6 no set while full", status[2], 1'b0);
    endtask

    task automatic t_late_mode();
        eng_tx_load = 1; tick(); idle();
        tend_late = 1; eng_last_bit = 1; tick(); idle();
        chk("R7 not yet", status[2], 1'b0);
        tick();
        chk("R7 set", status[2], 1'b1);
        tend_late = 0;
    endtask

    task automatic t_rx();
        eng_rx_done = 1; eng_rx_word = 8'h3C; tick(); idle();
        chk("R8 full", status[0], 1'b1);
        chk("R8 data", rxd_out, 8'h3C);
        cpu_rxd_rd = 1; tick(); idle();
        chk("R9", status[0], 1'b0);
    endtask

    task automatic t_arming();
        eng_rx_done = 1; eng_rx_word = 8'h77; tick(); idle();
        cpu_stat_wr = 1; cpu_wdata = 3'b110; tick(); idle();
        chk("R10 blind write", status[0], 1'b1);
        cpu_stat_rd = 1; tick(); idle();
        cpu_stat_wr = 1; cpu_wdata = 3'b110; tick(); idle();
        chk("R10 armed clear", status[0], 1'b0);
        cpu_stat_rd = 1; tick(); idle();
        cpu_stat_wr = 1; cpu_wdata = 3'b111; tick(); idle();
        chk("R10 write one", status[2], 1'b1);
        cpu_stat_wr = 1; cpu_wdata = 3'b011; tick(); idle();
        chk("R10 arm consumed", status[2], 1'b1);
        cpu_stat_rd = 1; tick(); idle();
        cpu_stat_wr = 1; cpu_wdata = 3'b101; tick(); idle();
        chk("R10 free cleared", status[1], 1'b0);
        chk("R12", {irq_tend, irq_tdre, irq_rdrf}, status);
    endtask

    task automatic t_set_wins();
        eng_rx_done = 1; tick(); idle();
        cpu_stat_rd = 1; tick(); idle();
        cpu_stat_wr = 1; cpu_wdata = 3'b110; eng_rx_done = 1; tick(); idle();
        chk("R11", status[0], 1'b1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; tick();
        t_reset();
        t_disabled_write();
        t_tx_flow();
        t_early_blocked();
        t_late_mode();
        t_rx();
        t_arming();
        t_set_wins();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule